// File: doc/BRIEF.md
# External Bus Width Adapter

This block sits between a CPU-side transfer port and an external data bus of 16 bits. The CPU side issues one request at a time: a byte, word or longword transfer with an address and, for writes, 32 bits of right-justified data. A single select input tells the block whether the addressed region is 16 bits wide or 8 bits wide. The block breaks the request into the external cycles that this width needs and runs them one after another. For each cycle it drives the address, the active-low lane strobes and the write data.

Byte order is big-endian. The most significant part goes first, at the lowest address. The address advances by the size of each cycle's transfer. On reads, the block shifts each returned chunk into an accumulator, so the final result comes back right-justified and zero-extended. Each external cycle holds its outputs steady until the bus acknowledges it. After the last acknowledge, the block returns a response to the CPU side for a single clock.

Top module: `ext_bus_sizer`

## Requirements
- R1: In a 16-bit region (`region_16`=1), a word request (`req_size`=2'b01) makes one external cycle at the request address, with `bus_ub_n`=0 and `bus_lb_n`=0, and write data `req_wdata[15:0]` on `bus_wdata[15:0]`.
- R2: In a 16-bit region, a longword request (`req_size`=2'b10) makes two word cycles. The first is at the request address and carries `req_wdata[31:16]`. The second is at address+2 and carries `req_wdata[15:0]`. Both lanes are strobed in both cycles.
- R3: In a 16-bit region, a byte request (`req_size`=2'b00) makes one cycle. At an even address it uses only the upper lane: `bus_ub_n`=0, `bus_lb_n`=1, data on bits 15:8. At an odd address it uses only the lower lane: `bus_ub_n`=1, `bus_lb_n`=0, data on bits 7:0.
- R4: In an 8-bit region (`region_16`=0), byte, word and longword requests take 1, 2 and 4 cycles. The address starts at the request address and goes up by 1 each cycle, with the most significant byte first. Every cycle uses only the upper lane (`bus_ub_n`=0, `bus_lb_n`=1, data on bits 15:8).
- R5: A read returns the fetched bytes big-endian and right-justified in `rsp_rdata`. The bytes are zero-extended for byte and word sizes. Data on unstrobed lanes, and data present when `bus_ack` is low, has no effect. A write returns `rsp_rdata`=0.
- R6: A word or longword request with address bit 0 set, or a request with the reserved size code 2'b11, starts no external cycle. It gets `rsp_valid`=1 with `rsp_err`=1 in the clock after acceptance. A good request returns `rsp_err`=0.
- R7: `req_ready` is high only while the block is idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high.
- R8: While `bus_cyc` is high and `bus_ack` is low, the following are held unchanged into the next clock: `bus_cyc`, `bus_addr`, `bus_ub_n`, `bus_lb_n`, `bus_wdata` and `bus_we`. `bus_we` equals the request's write flag.
- R9: `rsp_valid` is high for exactly one clock. That clock directly follows the edge that samples `bus_ack` high on the last cycle. `req_ready` returns high in the clock after that.
- R10: An active-low `rst_n` puts the block idle at once, even during a transfer: `req_ready`=1, `bus_cyc`=0, `rsp_valid`=0 and both lane strobes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 word, 10 longword, 11 reserved |
| req_addr | input | AW | Byte address of the request |
| req_wdata | input | 32 | Right-justified write data |
| region_16 | input | 1 | 1 = 16-bit region, 0 = 8-bit region |
| rsp_valid | output | 1 | One-clock response pulse |
| rsp_err | output | 1 | Request rejected (valid with rsp_valid) |
| rsp_rdata | output | 32 | Right-justified read result |
| bus_cyc | output | 1 | External cycle in progress |
| bus_we | output | 1 | External cycle is a write |
| bus_addr | output | AW | External cycle address |
| bus_ub_n | output | 1 | Upper lane (15:8) strobe, active low |
| bus_lb_n | output | 1 | Lower lane (7:0) strobe, active low |
| bus_wdata | output | 16 | External write data |
| bus_rdata | input | 16 | External read data |
| bus_ack | input | 1 | Ends the current external cycle |

## Verification
The bench covers every combination of region width, size code and direction, at eight consecutive addresses that cover both parities and all four alignments modulo 4. The bench checks every clock of every external cycle against an expected address, strobe pair and data chunk. Acknowledge delays vary with the cycle index, which separates a correct hold from outputs that move early. Each address returns a distinct byte and unstrobed lanes carry junk, so read results expose swapped lanes, wrong byte order or a missing zero-extension. Odd addresses with word and longword sizes, and size code 11, exercise the rejection path. A reset during a transfer exercises the return to idle.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

  localparam int BYTE_W = 8;
  localparam int LANE_W = 16;
  localparam int DATA_W = 32;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b01;
  localparam logic [1:0] SZ_LONG = 2'b10;
  localparam logic [1:0] SZ_RSV  = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_BUS  = 2'b01,
    ST_RESP = 2'b10
  } seq_state_e;

  // number of external cycles for one request
  function automatic logic [2:0] cycle_count(input logic wide, input logic [1:0] sz);
    logic [2:0] n;
    if (wide) n = (sz == SZ_LONG) ? 3'd2 : 3'd1;
    else      n = (sz == SZ_LONG) ? 3'd4 : (sz == SZ_WORD) ? 3'd2 : 3'd1;
    return n;
  endfunction

  // whole request length in bytes
  function automatic logic [2:0] byte_count(input logic [1:0] sz);
    return (sz == SZ_LONG) ? 3'd4 : (sz == SZ_WORD) ? 3'd2 : 3'd1;
  endfunction

endpackage

// File: rtl/ebs_lane_map.sv
module ebs_lane_map
  import ebs_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              wide,
  input  logic [1:0]        size,
  input  logic              write,
  input  logic [AW-1:0]     base_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        idx,
  input  logic [LANE_W-1:0] bus_rdata,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_ub_n,
  output logic              bus_lb_n,
  output logic [LANE_W-1:0] bus_wdata,
  output logic [LANE_W-1:0] chunk
);

  logic              word_cyc;
  logic              low_lane;
  logic [AW-1:0]     offset;
  logic [2:0]        pos3;
  logic [1:0]        byte_pos;
  logic [BYTE_W-1:0] wbyte;
  logic [LANE_W-1:0] wword;

  assign word_cyc = wide && (size != SZ_BYTE);
  assign low_lane = wide && (size == SZ_BYTE) && base_addr[0];

  always_comb begin
    offset = '0;
    offset[2:0] = word_cyc ? {idx, 1'b0} : {1'b0, idx};
  end

  assign bus_addr = base_addr + offset;

  // byte picked MSB-first out of the request
  assign pos3     = byte_count(size) - 3'd1 - {1'b0, idx};
  assign byte_pos = pos3[1:0];
  assign wbyte    = wdata[{byte_pos, 3'b000} +: BYTE_W];
  assign wword    = ((size == SZ_LONG) && !idx[0]) ? wdata[31:16] : wdata[15:0];

  always_comb begin
    bus_ub_n  = 1'b1;
    bus_lb_n  = 1'b1;
    bus_wdata = '0;
    if (active) begin
      if (word_cyc) begin
        bus_ub_n = 1'b0;
        bus_lb_n = 1'b0;
      end else if (low_lane) begin
        bus_lb_n = 1'b0;
      end else begin
        bus_ub_n = 1'b0;
      end
      if (write) begin
        if (word_cyc)      bus_wdata = wword;
        else if (low_lane) bus_wdata = {8'h00, wbyte};
        else               bus_wdata = {wbyte, 8'h00};
      end
    end
  end

  always_comb begin
    if (word_cyc)      chunk = bus_rdata;
    else if (low_lane) chunk = {8'h00, bus_rdata[7:0]};
    else               chunk = {8'h00, bus_rdata[15:8]};
  end

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    active && !wide |-> !bus_ub_n && bus_lb_n); // R4
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    active && (size == SZ_BYTE) |-> $countones({bus_ub_n, bus_lb_n}) == 1); // R3
  AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> bus_ub_n && bus_lb_n); // R10

endmodule

// File: rtl/ebs_seq.sv
module ebs_seq
  import ebs_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              region_16,
  input  logic              bus_ack,
  input  logic [LANE_W-1:0] chunk,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              act,
  output logic              lat_wide,
  output logic              lat_write,
  output logic [1:0]        lat_size,
  output logic [AW-1:0]     lat_addr,
  output logic [DATA_W-1:0] lat_wdata,
  output logic [1:0]        idx
);

  seq_state_e        state_q, state_d;
  logic [1:0]        idx_q, idx_d;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              err_q, err_d;
  logic              load;
  logic              accept;
  logic              misalign;
  logic              last;
  logic [2:0]        ncyc;

  assign accept   = req_valid && (state_q == ST_IDLE);
  assign misalign = (req_size == SZ_RSV) || ((req_size != SZ_BYTE) && req_addr[0]);
  assign ncyc     = cycle_count(lat_wide, lat_size);
  assign last     = ({1'b0, idx_q} == (ncyc - 3'd1));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    acc_d   = acc_q;
    err_d   = err_q;
    load    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          load    = 1'b1;
          idx_d   = '0;
          acc_d   = '0;
          err_d   = misalign;
          state_d = misalign ? ST_RESP : ST_BUS;
        end
      end
      ST_BUS: begin
        if (bus_ack) begin
          if (!lat_write) begin
            if (lat_wide && (lat_size != SZ_BYTE)) acc_d = {acc_q[15:0], chunk};
            else                                   acc_d = {acc_q[23:0], chunk[7:0]};
          end
          if (last) state_d = ST_RESP;
          else      idx_d   = idx_q + 2'd1;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      acc_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      acc_q   <= acc_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_wide  <= 1'b0;
      lat_write <= 1'b0;
      lat_size  <= SZ_BYTE;
      lat_addr  <= '0;
      lat_wdata <= '0;
    end else if (load) begin
      lat_wide  <= region_16;
      lat_write <= req_write;
      lat_size  <= req_size;
      lat_addr  <= req_addr;
      lat_wdata <= req_wdata;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_err   = rsp_valid && err_q;
  assign rsp_rdata = acc_q;
  assign act       = (state_q == ST_BUS);
  assign idx       = idx_q;

  AST_ERR_SKIPS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && misalign |=> rsp_valid && rsp_err && !act); // R6
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready); // R9
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !act && !rsp_valid); // R7
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> ({1'b0, idx_q} < ncyc)); // R4

endmodule

// File: rtl/ext_bus_sizer.sv
module ext_bus_sizer
  import ebs_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [AW-1:0]     req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              region_16,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              bus_cyc,
  output logic              bus_we,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_ub_n,
  output logic              bus_lb_n,
  output logic [15:0]       bus_wdata,
  input  logic [15:0]       bus_rdata,
  input  logic              bus_ack
);

  logic              act;
  logic              lat_wide;
  logic              lat_write;
  logic [1:0]        lat_size;
  logic [AW-1:0]     lat_addr;
  logic [DATA_W-1:0] lat_wdata;
  logic [1:0]        idx;
  logic [LANE_W-1:0] chunk;

  ebs_seq #(.AW(AW)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .region_16 (region_16),
    .bus_ack   (bus_ack),
    .chunk     (chunk),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .act       (act),
    .lat_wide  (lat_wide),
    .lat_write (lat_write),
    .lat_size  (lat_size),
    .lat_addr  (lat_addr),
    .lat_wdata (lat_wdata),
    .idx       (idx)
  );

  ebs_lane_map #(.AW(AW)) lane_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (act),
    .wide      (lat_wide),
    .size      (lat_size),
    .write     (lat_write),
    .base_addr (lat_addr),
    .wdata     (lat_wdata),
    .idx       (idx),
    .bus_rdata (bus_rdata),
    .bus_addr  (bus_addr),
    .bus_ub_n  (bus_ub_n),
    .bus_lb_n  (bus_lb_n),
    .bus_wdata (bus_wdata),
    .chunk     (chunk)
  );

  assign bus_cyc = act;
  assign bus_we  = act && lat_write;

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && !bus_ack |=> bus_cyc && $stable(bus_addr) && $stable(bus_ub_n)
      && $stable(bus_lb_n) && $stable(bus_wdata) && $stable(bus_we)); // R8
  AST_NO_CYC_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_cyc && bus_ub_n && bus_lb_n); // R7

endmodule

// File: tb/ext_bus_sizer_tb_top.sv
`timescale 1ns/1ps
module ext_bus_sizer_tb_top;

  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_write, region_16;
  logic [1:0]    req_size;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_wdata;
  logic          rsp_valid, rsp_err;
  logic [31:0]   rsp_rdata;
  logic          bus_cyc, bus_we, bus_ub_n, bus_lb_n, bus_ack;
  logic [AW-1:0] bus_addr;
  logic [15:0]   bus_wdata, bus_rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  ext_bus_sizer #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .region_16(region_16), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .bus_cyc(bus_cyc), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_ub_n(bus_ub_n), .bus_lb_n(bus_lb_n),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      errors = errors + 1;
      $display("FAIL R9 watchdog expired: actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    logic [AW-1:0] t;
    t = a * 24'd37 + 24'd11;
    return t[7:0];
  endfunction

  task automatic check_idle(input string req);
    chk(req_ready == 1'b1, req, "req_ready idle", 32'(req_ready), 32'd1);
    chk(bus_cyc == 1'b0, req, "bus_cyc idle", 32'(bus_cyc), 32'd0);
    chk(rsp_valid == 1'b0, req, "rsp_valid idle", 32'(rsp_valid), 32'd0);
    chk({bus_ub_n, bus_lb_n} == 2'b11, req, "strobes idle", 32'({bus_ub_n, bus_lb_n}), 32'd3);
  endtask

  task automatic run(input logic wide, input logic [1:0] sz, input logic wr,
                     input logic [AW-1:0] addr, input logic [31:0] wd);
    logic          bad;
    logic          word_cyc;
    int            nb, ncyc, k, wcnt, dly, guard;
    bit            done;
    logic [AW-1:0] ea;
    logic [1:0]    es;
    logic [15:0]   ew;
    logic [7:0]    b;
    logic [31:0]   erd;

    bad      = (sz == 2'b11) || ((sz != 2'b00) && addr[0]);
    word_cyc = wide && (sz != 2'b00);
    nb       = (sz == 2'b10) ? 4 : (sz == 2'b01) ? 2 : 1;
    ncyc     = bad ? 0 : wide ? ((sz == 2'b10) ? 2 : 1) : nb;
    erd      = '0;
    if (!wr && !bad)
      for (int i = 0; i < nb; i++) erd = (erd << 8) | 32'(mem_byte(addr + AW'(i)));

    @(negedge clk);
    chk(req_ready == 1'b1, "R7", "ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr;
    req_wdata = wd; region_16 = wide;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R7", "ready after accept", 32'(req_ready), 32'd0);

    k = 0; wcnt = 0; guard = 0; done = 0;
    while (!done && guard < 60) begin
      if (rsp_valid) begin
        chk(rsp_err == bad, "R6", "rsp_err", 32'(rsp_err), 32'(bad));
        chk(k == ncyc, bad ? "R6" : "R4", "external cycle count", 32'(k), 32'(ncyc));
        chk(rsp_rdata == erd, "R5", "read result", rsp_rdata, erd);
        done = 1;
      end else if (bus_cyc) begin
        ea = word_cyc ? addr + AW'(2 * k) : addr + AW'(k);
        es = word_cyc ? 2'b00 : (wide && addr[0]) ? 2'b10 : 2'b01;
        if (word_cyc) ew = (sz == 2'b10 && k == 0) ? wd[31:16] : wd[15:0];
        else begin
          b  = 8'(wd >> (8 * (nb - 1 - k)));
          ew = (wide && addr[0]) ? {8'h00, b} : {b, 8'h00};
        end
        chk(k < ncyc, "R6", "cycle beyond expected", 32'(k), 32'(ncyc));
        chk(bus_addr == ea, word_cyc ? "R2" : "R4", "bus_addr", 32'(bus_addr), 32'(ea));
        chk({bus_ub_n, bus_lb_n} == es, word_cyc ? "R1" : "R3", "strobes",
            32'({bus_ub_n, bus_lb_n}), 32'(es));
        chk(bus_we == wr, "R8", "bus_we", 32'(bus_we), 32'(wr));
        if (wr) chk(bus_wdata == ew, (sz == 2'b10) ? "R2" : "R1", "bus_wdata",
                    32'(bus_wdata), 32'(ew));
        dly = (k + int'(addr[1:0])) % 3;
        if (wcnt >= dly) begin
          bus_ack = 1'b1;
          if (word_cyc) bus_rdata = {mem_byte(ea), mem_byte(ea + AW'(1))};
          else if (wide && addr[0]) bus_rdata = {8'hC3 ^ ea[7:0], mem_byte(ea)};
          else bus_rdata = {mem_byte(ea), 8'h3C ^ ea[7:0]};
        end else begin
          bus_rdata = 16'hDEAD;
        end
        wcnt++;
      end else begin
        chk(1'b0, "R9", "no cycle and no response", 32'd0, 32'd1);
      end
      @(negedge clk);
      guard++;
      if (bus_ack) begin
        bus_ack = 1'b0; bus_rdata = 16'hBEEF; k++; wcnt = 0;
      end
    end
    chk(done, "R9", "response seen", 32'(done), 32'd1);
    chk(rsp_valid == 1'b0, "R9", "rsp_valid one clock", 32'(rsp_valid), 32'd0);
    chk(req_ready == 1'b1, "R9", "ready after response", 32'(req_ready), 32'd1);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'b00;
    req_addr = '0; req_wdata = '0; region_16 = 1'b1; bus_ack = 1'b0;
    bus_rdata = 16'h0000;
    repeat (3) @(negedge clk);
    check_idle("R10");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R10");

    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 4; s++)
        for (int d = 0; d < 2; d++)
          for (int a = 0; a < 8; a++)
            run(w[0], s[1:0], d[0], AW'(24'h0007F8 + a),
                32'hA1B2_C3D4 ^ (32'(a) * 32'h0101_0101) ^ (32'(s) << 28));

    // reset during a narrow longword transfer
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'b10; req_addr = 24'h000100;
    req_wdata = 32'h1122_3344; region_16 = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(bus_cyc == 1'b1, "R10", "transfer running before reset", 32'(bus_cyc), 32'd1);
    rst_n = 1'b0;
    #1;
    check_idle("R10");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R10");
    run(1'b1, 2'b01, 1'b0, 24'h000200, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule